// File: doc/BRIEF.md
# Interrupt Arbitration and Trap Entry Controller

This block sits beside a processor's fetch stage and decides when the core must leave its normal instruction stream. Each cycle it looks at four interrupt request lines and at the priority level held in the processor status. It picks the most urgent request that the level does not mask, and accepts it only while the core is outside its privileged handler mode. A synchronous exception request (memory fault, arithmetic trap, unaligned access, illegal opcode, call-gate instruction and the like) always wins over an interrupt seen in the same cycle. Such a request is accepted whether or not the core is in handler mode.

When an entry is accepted, the block produces a one-cycle entry strobe and three results. The first is the return address: the current PC, with the handler-mode flag ORed into bit 0 so the return path knows which mode to resume. The second is the handler target: the handler base register plus an offset chosen by the cause code. The third is an updated handler-mode flag, which the core adopts. Fixed causes use slots spaced 0x100 apart. Call-gate codes from 0x80 upward use a dense table of 64-byte slots starting at 0x2000. All outputs are registered.

Top module: `trap_entry_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the next outputs are all zero: `ent_valid`, `ent_cause`, `ent_pc`, `ent_ret` and `ent_hmode`.
- R2: When `hmode_in` is 1 and `exc_req` is 0, no interrupt is accepted and `ent_valid` is 0 one cycle later, whatever `irq_req` and `ipl` are.
- R3: Request line `irq_req[i]` is eligible only when `ipl` <= 3+i. Bit 0 is the device line, bit 1 the clock, bit 2 the interprocessor line and bit 3 machine check, so a level of 7 masks every line.
- R4: Among eligible lines the highest bit index wins. The accepted cause code is 4 for device, 3 for clock, 2 for interprocessor and 1 for machine check.
- R5: On an entry, `ent_ret` equals `cur_pc` ORed with `hmode_in` in bit 0, both taken from the cycle the entry was accepted.
- R6: On an entry, `ent_pc` equals `hbase` plus the cause offset, and `ent_hmode` is 1. Without an entry, `ent_hmode` copies the previous cycle's `hmode_in`.
- R7: Fixed cause codes 0 to 8 (0 reset, 1 machine check, 2 interprocessor, 3 clock, 4 device, 5 memory fault, 6 arithmetic, 7 unaligned, 8 illegal opcode) use offset code × 0x100. Any other code below 0x80 uses the illegal-opcode offset 0x800.
- R8: A cause code c >= 0x80 is a call-gate entry with offset 0x2000 + (c − 0x80) × 64.
- R9: When `exc_req` is 1, the entry taken one cycle later carries `exc_code` as its cause. This holds even with eligible interrupts pending and even in handler mode.
- R10: Entries appear exactly one cycle after acceptance, with `ent_valid` high for that one cycle. In cycles without an entry, `ent_cause`, `ent_pc` and `ent_ret` keep their last values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 4 | Interrupt requests: [0] device, [1] clock, [2] interprocessor, [3] machine check |
| ipl | input | 3 | Current interrupt priority level |
| hmode_in | input | 1 | Core is in privileged handler mode |
| cur_pc | input | 64 | PC of the instruction being interrupted |
| hbase | input | 64 | Handler base address |
| exc_req | input | 1 | Synchronous exception request |
| exc_code | input | 8 | Cause code of the synchronous exception |
| ent_valid | output | 1 | One-cycle entry strobe |
| ent_cause | output | 8 | Cause code of the last entry |
| ent_pc | output | 64 | Handler target address of the last entry |
| ent_ret | output | 64 | Return address with mode tag in bit 0 |
| ent_hmode | output | 1 | Handler-mode flag the core adopts |

## Verification
Some rules are checked by assertions on every cycle:
- handler mode blocks interrupts;
- a granted line really was eligible at the current level;
- a synchronous request produces its own cause one cycle later;
- the return tag carries the prior mode;
- every entry raises the mode flag;
- call-gate targets stay inside their window above the base.

The exact offset of each code, the strict priority order between several eligible lines, and the holding of results between entries are shown only by the bench. It sweeps every request pattern against every level and both modes, and every cause code, comparing against arithmetic expectations.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int CAUSE_W    = 8;
  localparam int SLOT_SHIFT = 6;     // call-gate slot of 64 bytes
  localparam int FIX_SHIFT  = 8;     // fixed slots spaced 0x100
  localparam int GATE_BASE  = 'h2000;

  localparam logic [CAUSE_W-1:0] C_RESET  = 8'd0;
  localparam logic [CAUSE_W-1:0] C_MCHK   = 8'd1;
  localparam logic [CAUSE_W-1:0] C_IPI    = 8'd2;
  localparam logic [CAUSE_W-1:0] C_TICK   = 8'd3;
  localparam logic [CAUSE_W-1:0] C_DEV    = 8'd4;
  localparam logic [CAUSE_W-1:0] C_MEMF   = 8'd5;
  localparam logic [CAUSE_W-1:0] C_ARITH  = 8'd6;
  localparam logic [CAUSE_W-1:0] C_UNAL   = 8'd7;
  localparam logic [CAUSE_W-1:0] C_OPDEC  = 8'd8;
endpackage

// File: rtl/trap_irq_pick.sv
module trap_irq_pick #(
  parameter int NUM_IRQ = 4,
  parameter int IPL_W   = 3,
  parameter int LOW_LVL = 3,
  localparam int IDX_W  = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] req,
  input  logic [IPL_W-1:0]   ipl,
  input  logic               blocked,
  output logic               any,
  output logic [IDX_W-1:0]   idx
);
  logic [NUM_IRQ-1:0] elig;

  // each line has its own level ceiling, one step higher per line
  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line
    localparam logic [IPL_W:0] CEIL = (IPL_W+1)'(LOW_LVL + g);
    assign elig[g] = req[g] && !blocked && ({1'b0, ipl} <= CEIL);
  end

  // highest index is the most urgent
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (elig[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end

  // R2: nothing granted while blocked
  assert_blocked_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    blocked |-> !any);

  // R3: the granted line is requested and within its level ceiling
  assert_grant_eligible_R3: assert property (@(posedge clk) disable iff (rst)
    any |-> (req[idx] && ({1'b0, ipl} <= ((IPL_W+1)'(LOW_LVL) + (IPL_W+1)'(idx)))));
endmodule

// File: rtl/trap_vec_gen.sv
module trap_vec_gen
  import trap_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [CAUSE_W-1:0] code,
  output logic [XLEN-1:0]    offset
);
  logic is_gate;
  logic known_fixed;

  assign is_gate     = code[CAUSE_W-1];
  assign known_fixed = (code <= C_OPDEC);

  always_comb begin
    if (is_gate)
      offset = XLEN'(GATE_BASE) + (XLEN'(code[CAUSE_W-2:0]) << SLOT_SHIFT);
    else if (known_fixed)
      offset = XLEN'(code) << FIX_SHIFT;
    else
      offset = XLEN'(C_OPDEC) << FIX_SHIFT;
  end
endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
  import trap_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int NUM_IRQ = 4,
  parameter int IPL_W   = 3,
  parameter int LOW_LVL = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic [IPL_W-1:0]   ipl,
  input  logic               hmode_in,
  input  logic [XLEN-1:0]    cur_pc,
  input  logic [XLEN-1:0]    hbase,
  input  logic               exc_req,
  input  logic [CAUSE_W-1:0] exc_code,
  output logic               ent_valid,
  output logic [CAUSE_W-1:0] ent_cause,
  output logic [XLEN-1:0]    ent_pc,
  output logic [XLEN-1:0]    ent_ret,
  output logic               ent_hmode
);
  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

  logic               irq_any;
  logic [IDX_W-1:0]   irq_idx;
  logic [CAUSE_W-1:0] irq_code;
  logic [CAUSE_W-1:0] sel_code;
  logic [XLEN-1:0]    sel_off;
  logic               take;

  trap_irq_pick #(
    .NUM_IRQ (NUM_IRQ),
    .IPL_W   (IPL_W),
    .LOW_LVL (LOW_LVL)
  ) u_pick (
    .clk     (clk),
    .rst     (rst),
    .req     (irq_req),
    .ipl     (ipl),
    .blocked (hmode_in),
    .any     (irq_any),
    .idx     (irq_idx)
  );

  // most urgent line (top index) maps to the lowest code
  assign irq_code = CAUSE_W'(NUM_IRQ) - CAUSE_W'(irq_idx);
  assign sel_code = exc_req ? exc_code : irq_code;
  assign take     = exc_req || irq_any;

  trap_vec_gen #(.XLEN(XLEN)) u_vec (
    .code   (sel_code),
    .offset (sel_off)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ent_valid <= 1'b0;
      ent_cause <= '0;
      ent_pc    <= '0;
      ent_ret   <= '0;
      ent_hmode <= 1'b0;
    end else begin
      ent_valid <= take;
      ent_hmode <= take || hmode_in;
      if (take) begin
        ent_cause <= sel_code;
        ent_pc    <= hbase + sel_off;
        ent_ret   <= cur_pc | XLEN'(hmode_in);
      end
    end
  end

  // R2: an entry in handler mode can only come from a synchronous request
  assert_hmode_no_irq_R2: assert property (@(posedge clk) disable iff (rst)
    (ent_valid && !$past(exc_req)) |-> !$past(hmode_in));

  // R9: synchronous request wins and shows its own code next cycle
  assert_sync_wins_R9: assert property (@(posedge clk) disable iff (rst)
    exc_req |=> (ent_valid && ent_cause == $past(exc_code)));

  // R5: return tag carries the prior mode
  assert_ret_tag_R5: assert property (@(posedge clk) disable iff (rst)
    ent_valid |-> (ent_ret[0] == ($past(hmode_in) | $past(cur_pc[0]))));

  // R6: every entry switches into handler mode
  assert_enter_hmode_R6: assert property (@(posedge clk) disable iff (rst)
    ent_valid |-> ent_hmode);

  // R8: call-gate targets stay within their window above the base
  assert_gate_window_R8: assert property (@(posedge clk) disable iff (rst)
    (ent_valid && ent_cause[CAUSE_W-1]) |->
      ((ent_pc - $past(hbase)) >= XLEN'(GATE_BASE) &&
       (ent_pc - $past(hbase)) <  XLEN'(GATE_BASE + (1 << (CAUSE_W-1+SLOT_SHIFT)))));
endmodule

// File: tb/tb_trap_entry_ctrl.sv
`timescale 1ns/1ps
module tb_trap_entry_ctrl;
  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  irq_req;
  logic [2:0]  ipl;
  logic        hmode_in;
  logic [63:0] cur_pc;
  logic [63:0] hbase;
  logic        exc_req;
  logic [7:0]  exc_code;
  logic        ent_valid;
  logic [7:0]  ent_cause;
  logic [63:0] ent_pc;
  logic [63:0] ent_ret;
  logic        ent_hmode;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  trap_entry_ctrl dut (
    .clk(clk), .rst(rst), .irq_req(irq_req), .ipl(ipl), .hmode_in(hmode_in),
    .cur_pc(cur_pc), .hbase(hbase), .exc_req(exc_req), .exc_code(exc_code),
    .ent_valid(ent_valid), .ent_cause(ent_cause), .ent_pc(ent_pc),
    .ent_ret(ent_ret), .ent_hmode(ent_hmode)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] off_of(input int code);
    if (code >= 128) return 64'(32'h2000 + (code - 128) * 64);
    else if (code <= 8) return 64'(code * 256);
    else return 64'h800;
  endfunction

  // drive one scenario at a falling edge, check at the next falling edge
  task automatic run(input logic [3:0] irq, input int lvl, input logic hm,
                     input logic ex, input int code, input logic [63:0] pc,
                     input logic [63:0] base, input string tag);
    logic e_take;
    int   e_code;
    e_take = 1'b0;
    e_code = 0;
    irq_req = irq; ipl = 3'(lvl); hmode_in = hm; exc_req = ex;
    exc_code = 8'(code); cur_pc = pc; hbase = base;
    if (ex) begin
      e_take = 1'b1; e_code = code;
    end else if (!hm) begin
      for (int i = 3; i >= 0; i--) begin
        if (!e_take && irq[i] && lvl <= 3 + i) begin
          e_take = 1'b1; e_code = 4 - i;
        end
      end
    end
    @(negedge clk);
    chk({tag, " valid"}, 64'(ent_valid), 64'(e_take));
    chk({tag, " R6 hmode"}, 64'(ent_hmode), 64'(e_take | hm));
    if (e_take) begin
      chk({tag, " cause"}, 64'(ent_cause), 64'(e_code));
      chk({tag, " R6 target"}, ent_pc, base + off_of(e_code));
      chk({tag, " R5 ret"}, ent_ret, pc | 64'(hm));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R10 watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; irq_req = '0; ipl = '0; hmode_in = 1'b0; cur_pc = '0;
    hbase = '0; exc_req = 1'b0; exc_code = '0;
    // R1: reset clears everything even with requests present
    @(negedge clk); irq_req = 4'hF; exc_req = 1'b1; exc_code = 8'h85;
    @(negedge clk); @(negedge clk);
    chk("R1 valid", 64'(ent_valid), 0);
    chk("R1 cause", 64'(ent_cause), 0);
    chk("R1 pc", ent_pc, 0);
    chk("R1 ret", ent_ret, 0);
    chk("R1 hmode", 64'(ent_hmode), 0);
    rst = 1'b0; exc_req = 1'b0; irq_req = '0;
    @(negedge clk);

    // R2 R3 R4: every request pattern, every level, both modes
    for (int hm = 0; hm < 2; hm++)
      for (int lv = 0; lv < 8; lv++)
        for (int rq = 0; rq < 16; rq++)
          run(4'(rq), lv, 1'(hm), 1'b0, 0,
              64'h0000_0012_3450_0000 + 64'(rq * 4 + lv * 64),
              64'hFFFF_FC00_0010_0000 + 64'(lv * 32'h10000), "R2 R3 R4 irq");

    // R7 R8 R9: every cause code, with all lines pending at level 0
    for (int c = 0; c < 256; c++)
      run(4'hF, 0, 1'(c % 2), 1'b1, c, 64'h0000_0000_2000_0000 + 64'(c * 4),
          64'h0000_0100_0000_0000 + 64'(c * 32'h20000),
          (c >= 128) ? "R8 R9 gate" : "R7 R9 fixed");

    // R10: a quiet cycle after an entry keeps the stored results
    run(4'b0100, 2, 1'b0, 1'b0, 0, 64'h40, 64'h1_0000, "R10 setup");
    irq_req = '0; exc_req = 1'b0; cur_pc = 64'hDEAD_0000; hbase = 64'hBEEF_0000;
    @(negedge clk);
    chk("R10 strobe drops", 64'(ent_valid), 0);
    chk("R10 pc held", ent_pc, 64'h1_0200);
    chk("R10 ret held", ent_ret, 64'h40);
    chk("R10 cause held", 64'(ent_cause), 2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule